// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the device-side logic of a two-wire in-circuit programming port. A host toggles a serial clock pin and drives a data pin. The block passes both through a synchroniser into a fast system clock domain and detects their edges there. It assembles 6-bit commands and moves 16-clock data frames in both directions. For reads it takes over the data pin for the part of the frame that carries data. It also keeps the address counter that selects user program space, configuration space and the byte-wide data memory.

The memory is outside the block. The block presents an address, a space select and a write word. It raises single-cycle strobes for a word write, for an erase of the addressed data byte before a write, and for a bulk erase. It reads the word back combinationally. Programming and erase times are stood in for by a cycle counter that holds `busy` high. Commands decoded while `busy` is high are dropped and flagged. The high-voltage entry condition is modelled by the level input `prog_en`: taking it low returns the block to its entry state.

Top module: `serprog_target`

## Requirements
- R1: A command is 6 bits, sampled at the synchronised falling edges of the serial clock, first bit received = bit 0. Unless stated otherwise, bits 5:4 are don't-care, so `110110` acts as increment. `101000` matches no command and has no effect.
- R2: A write frame is 16 serial clocks. The bits sampled at falling edges 2 to 15 form the 14-bit word, LSb first, and that word appears on `mem_wdata`.
- R3: In a read frame, `pdat_oe` rises after the 2nd rising edge of the frame. Bit k of the word is driven after rising edge k+2, a 0 is driven after rising edge 16, and the pin is released after the 16th falling edge. At all other times `pdat_oe` is 0.
- R4: Increment (`xx0110`) adds 1 to the low AW-1 counter bits and keeps the top bit. User space wraps from 2^(AW-1)-1 to 0, and configuration space wraps from its last address back to its base 2^(AW-1).
- R5: After reset, and whenever `prog_en` is low, the counter is 0 and both error flags are 0. Load Configuration (`xx0000`) sets the counter to 2^(AW-1) and loads a word. No other path moves the counter backwards.
- R6: Load data-memory (`xx0011`) and read data-memory (`xx0101`) select data space. In that space `mem_addr` carries only the low 7 counter bits, and the read word is the memory's low 8 bits with the upper 6 bits at zero.
- R7: With `lock_prog`=1, program-space reads in user space return 0, except at address CAL_ADDR. Configuration-space reads are never masked. With `lock_data`=1, data-space reads return 0.
- R8: Begin-internal (`001000`) after a load pulses `mem_we` once. It pulses `mem_pre_erase` with it when the load was to data space, and holds `busy` for exactly PROG_CYC cycles.
- R9: Begin-external (`011000`) after a load pulses `mem_we` without `mem_pre_erase`. `busy` then stays high until End (`001010`).
- R10: Bulk erase (`xx1001` program, `xx1011` data) pulses `mem_bulk` with `mem_dsel` at 0 or 1 and holds `busy` for exactly ERASE_CYC cycles.
- R11: While `busy` is high, any decoded command other than End during an external program is ignored, and the sticky flag `err_busy` is set.
- R12: A Begin with no load since the previous Begin writes nothing and sets the sticky flag `err_seq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_en | input | 1 | Programming mode active; low returns the block to its entry state |
| pclk_in | input | 1 | Serial clock pin |
| pdat_in | input | 1 | Serial data pin, input side |
| lock_prog | input | 1 | Program memory read protection |
| lock_data | input | 1 | Data memory read protection |
| mem_rdata | input | DW | Word read from the memory at `mem_addr` |
| pdat_out | output | 1 | Serial data pin, output value |
| pdat_oe | output | 1 | Serial data pin output enable |
| mem_addr | output | AW | Memory address (low 7 bits only in data space) |
| mem_dsel | output | 1 | 1 selects data memory, 0 selects program memory |
| mem_we | output | 1 | One-cycle word write strobe |
| mem_pre_erase | output | 1 | Erase the addressed data byte before this write |
| mem_bulk | output | 1 | One-cycle bulk erase strobe for the selected space |
| mem_wdata | output | DW | Word to be written |
| busy | output | 1 | Program or erase in progress |
| err_busy | output | 1 | Sticky: a command was dropped while busy |
| err_seq | output | 1 | Sticky: a Begin arrived without a preceding load |

## Verification
A counter error, such as a missed wrap, a lost top bit or aliasing that reaches too far, appears on `mem_addr` within a few system cycles of the command that caused it. The bench's model compares that address on every settled clock. A shift or frame-count error shows up as a wrong bit on the data pin, or as `pdat_oe` asserted in the wrong serial clock. It is visible at the end of the same frame, or as a word read back wrong in the next frame. Wrong busy bookkeeping shows as a strobe count, a busy length or an error flag that differs from the model right after the command concerned.

// File: rtl/serprog_target.sv
module serprog_target #(
  parameter int AW        = 14,
  parameter int DW        = 14,
  parameter int DBW       = 8,
  parameter int DAW       = 7,
  parameter int PROG_CYC  = 200,
  parameter int ERASE_CYC = 400,
  parameter logic [AW-1:0] CAL_ADDR = AW'('h3FF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic          pclk_in,
  input  logic          pdat_in,
  input  logic          lock_prog,
  input  logic          lock_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          pdat_out,
  output logic          pdat_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_dsel,
  output logic          mem_we,
  output logic          mem_pre_erase,
  output logic          mem_bulk,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          err_busy,
  output logic          err_seq
);
  localparam int CMDW = 6;
  localparam int FRM  = DW + 2;
  localparam int FW   = $clog2(FRM);
  localparam int TMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [AW-1:0]   CFG_BASE = AW'(1) << (AW - 1);
  localparam logic [CMDW-1:0] C_END    = 6'b001010;
  localparam logic [FW-1:0]   F_LAST   = FW'(FRM - 1);
  localparam logic [FW-1:0]   F_DLAST  = FW'(DW);
  localparam logic [2:0]      C_LAST   = 3'(CMDW - 1);

  logic [2:0]      cs;
  logic [1:0]      ds;
  logic [CMDW-2:0] csr;
  logic [2:0]      ccnt;
  logic [AW-1:0]   pc;
  logic            in_frm, rd_frm, loaded, ext_on;
  logic [FW-1:0]   fcnt;
  logic [DW-1:0]   wbuf, rbuf, rd_val;
  logic [TW-1:0]   tcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs <= '0;
      ds <= '0;
    end else begin
      cs <= {cs[1:0], pclk_in};
      ds <= {ds[0], pdat_in};
    end

  wire              fall   = cs[2] & ~cs[1];
  wire              rise   = ~cs[2] & cs[1];
  wire              din    = ds[1];
  wire [CMDW-1:0]   nc     = {din, csr};
  wire              last   = (ccnt == C_LAST);
  wire              accept = !busy || (ext_on && nc == C_END);
  wire              user_locked = !mem_dsel && lock_prog && !pc[AW-1] && (pc != CAL_ADDR);

  assign busy      = (tcnt != '0) | ext_on;
  assign mem_wdata = wbuf;
  assign mem_addr  = mem_dsel ? AW'(pc[DAW-1:0]) : pc;
  assign rd_val    = mem_dsel ? (lock_data ? '0 : DW'(mem_rdata[DBW-1:0]))
                              : (user_locked ? '0 : mem_rdata);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      csr <= '0; ccnt <= '0; pc <= '0; in_frm <= 1'b0; rd_frm <= 1'b0;
      fcnt <= '0; wbuf <= '0; rbuf <= '0; loaded <= 1'b0; ext_on <= 1'b0;
      tcnt <= '0; pdat_out <= 1'b0; pdat_oe <= 1'b0; mem_dsel <= 1'b0;
      mem_we <= 1'b0; mem_pre_erase <= 1'b0; mem_bulk <= 1'b0;
      err_busy <= 1'b0; err_seq <= 1'b0;
    end else if (!prog_en) begin
      csr <= '0; ccnt <= '0; pc <= '0; in_frm <= 1'b0; rd_frm <= 1'b0;
      fcnt <= '0; wbuf <= '0; rbuf <= '0; loaded <= 1'b0; ext_on <= 1'b0;
      tcnt <= '0; pdat_out <= 1'b0; pdat_oe <= 1'b0; mem_dsel <= 1'b0;
      mem_we <= 1'b0; mem_pre_erase <= 1'b0; mem_bulk <= 1'b0;
      err_busy <= 1'b0; err_seq <= 1'b0;
    end else begin
      mem_we        <= 1'b0;
      mem_pre_erase <= 1'b0;
      mem_bulk      <= 1'b0;
      if (tcnt != '0) tcnt <= tcnt - 1'b1;
      if (in_frm) begin
        if (rise) begin
          if (fcnt == '0) rbuf <= rd_val;
          else if (rd_frm) begin
            pdat_oe  <= 1'b1;
            pdat_out <= rbuf[0];
            rbuf     <= rbuf >> 1;
          end
        end
        if (fall) begin
          fcnt <= fcnt + 1'b1;
          if (!rd_frm && fcnt != '0 && fcnt <= F_DLAST) wbuf <= {din, wbuf[DW-1:1]};
          if (fcnt == F_LAST) begin
            in_frm   <= 1'b0;
            pdat_oe  <= 1'b0;
            pdat_out <= 1'b0;
          end
        end
      end else if (fall) begin
        csr  <= nc[CMDW-1:1];
        ccnt <= last ? '0 : ccnt + 1'b1;
        if (last) begin
          if (!accept) err_busy <= 1'b1;
          else begin
            case (nc[3:0])
              4'b0000: begin
                pc <= CFG_BASE; mem_dsel <= 1'b0; loaded <= 1'b1;
                in_frm <= 1'b1; rd_frm <= 1'b0; fcnt <= '0;
              end
              4'b0010, 4'b0011: begin
                mem_dsel <= nc[0]; loaded <= 1'b1;
                in_frm <= 1'b1; rd_frm <= 1'b0; fcnt <= '0;
              end
              4'b0100, 4'b0101: begin
                mem_dsel <= nc[0];
                in_frm <= 1'b1; rd_frm <= 1'b1; fcnt <= '0;
              end
              4'b0110: pc <= {pc[AW-1], pc[AW-2:0] + 1'b1};
              4'b1001, 4'b1011: begin
                mem_dsel <= nc[1]; mem_bulk <= 1'b1; tcnt <= TW'(ERASE_CYC);
              end
              4'b1000: if (!nc[5]) begin
                if (!loaded) err_seq <= 1'b1;
                else begin
                  mem_we <= 1'b1;
                  loaded <= 1'b0;
                  if (nc[4]) ext_on <= 1'b1;
                  else begin
                    tcnt          <= TW'(PROG_CYC);
                    mem_pre_erase <= mem_dsel;
                  end
                end
              end
              4'b1010: if (nc[5:4] == 2'b00) ext_on <= 1'b0;
              default: ;
            endcase
          end
        end
      end
    end

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && $past(prog_en) && $past(pc[AW-1])) |-> pc[AW-1]); // R4
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && $past(prog_en) && pc != $past(pc)) |->
      (pc == CFG_BASE || pc[AW-2:0] == (AW-1)'($past(pc[AW-2:0]) + 1'b1))); // R5
  AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pdat_oe |-> (in_frm && rd_frm)); // R3
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_bulk})); // R10
  AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R8
  AST_PRE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pre_erase |-> (mem_we && mem_dsel)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && $past(err_seq)) |-> err_seq); // R12
endmodule

// File: tb/serprog_target_bench.sv
module serprog_target_bench;
  localparam int AW = 10, DW = 14, PROG_CYC = 60, ERASE_CYC = 90, H = 4;
  localparam int CFGB = 'h200, LOWM = 'h1FF;

  logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b0, pclk = 1'b0, pdat = 1'b0;
  logic lock_prog = 1'b0, lock_data = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic pdat_out, pdat_oe, mem_dsel, mem_we, mem_pre_erase, mem_bulk, busy, err_busy, err_seq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  serprog_target #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                   .CAL_ADDR(10'h0FF)) u_serprog_target (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .pclk_in(pclk), .pdat_in(pdat),
    .lock_prog(lock_prog), .lock_data(lock_data), .mem_rdata(mem_rdata),
    .pdat_out(pdat_out), .pdat_oe(pdat_oe), .mem_addr(mem_addr), .mem_dsel(mem_dsel),
    .mem_we(mem_we), .mem_pre_erase(mem_pre_erase), .mem_bulk(mem_bulk),
    .mem_wdata(mem_wdata), .busy(busy), .err_busy(err_busy), .err_seq(err_seq));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [13:0] pmem [int];
  logic [7:0]  dmem [int];
  int we_cnt = 0, pre_cnt = 0, bulk_cnt = 0, bcnt = 0, blen = 0;
  bit track = 0, done = 0;
  int exp_pc = 0;
  bit exp_dsel = 0, exp_eb = 0, exp_es = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_we) begin
      we_cnt++;
      if (mem_dsel) dmem[int'(mem_addr[6:0])] = mem_wdata[7:0];
      else pmem[int'(mem_addr)] = mem_wdata;
    end
    if (mem_pre_erase) pre_cnt++;
    if (mem_bulk) begin
      bulk_cnt++;
      if (mem_dsel) dmem.delete(); else pmem.delete();
    end
    if (busy) bcnt++;
    else if (bcnt != 0) begin blen = bcnt; bcnt = 0; end
    if (mem_dsel) mem_rdata = dmem.exists(int'(mem_addr)) ? {6'b0, dmem[int'(mem_addr)]} : 14'h00FF;
    else mem_rdata = pmem.exists(int'(mem_addr)) ? pmem[int'(mem_addr)] : 14'h3FFF;
    if (track) begin
      chk("R4", "address", int'(mem_addr), exp_dsel ? (exp_pc & 'h7F) : exp_pc);
      chk("R11", "err_busy", int'(err_busy), int'(exp_eb));
      chk("R12", "err_seq", int'(err_seq), int'(exp_es));
      chk("R3", "idle oe", int'(pdat_oe), 0);
    end
  end

  task automatic bitx(input logic b);
    pdat = b; pclk = 1'b1;
    repeat (H) @(negedge clk);
    pclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cmd(input logic [5:0] c);
    track = 0;
    for (int i = 0; i < 6; i++) bitx(c[i]);
    repeat (6) @(negedge clk);
  endtask

  task automatic load(input logic [5:0] c, input logic [13:0] w);
    cmd(c);
    bitx(1'b0);
    for (int i = 0; i < 14; i++) bitx(w[i]);
    bitx(1'b0);
    repeat (6) @(negedge clk);
    if (c[3:0] == 4'b0000) begin exp_pc = CFGB; exp_dsel = 0; end
    else exp_dsel = c[0];
    track = 1;
  endtask

  task automatic rd(input logic [5:0] c, output logic [13:0] w);
    cmd(c);
    exp_dsel = c[0];
    w = '0;
    for (int k = 1; k <= 16; k++) begin
      pdat = 1'b0; pclk = 1'b1;
      repeat (H) @(negedge clk);
      if (k == 1) chk("R3", "oe at clock 1", int'(pdat_oe), 0);
      else begin
        chk("R3", "oe in frame", int'(pdat_oe), 1);
        if (k <= 15) w[k-2] = pdat_out;
        else chk("R3", "stop bit", int'(pdat_out), 0);
      end
      pclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    track = 1;
  endtask

  task automatic inc_n(input int n);
    for (int i = 0; i < n; i++) begin
      cmd(6'h06);
      exp_pc = (exp_pc & CFGB) | ((exp_pc + 1) & LOWM);
    end
    track = 1;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] w;
    int we0, pre0, bk0;
    repeat (5) @(negedge clk);
    chk("R5", "reset address", int'(mem_addr), 0);
    chk("R3", "reset oe", int'(pdat_oe), 0);
    chk("R8", "reset busy", int'(busy), 0);
    chk("R12", "reset err_seq", int'(err_seq), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    prog_en = 1'b1;
    repeat (3) @(negedge clk);
    track = 1;

    load(6'h02, 14'h1A5C);
    chk("R2", "write word", int'(mem_wdata), 'h1A5C);
    we0 = we_cnt; pre0 = pre_cnt;
    cmd(6'h08); track = 1;
    chk("R8", "busy after begin", int'(busy), 1);
    repeat (PROG_CYC + 20) @(negedge clk);
    chk("R8", "write strobes", we_cnt, we0 + 1);
    chk("R8", "no pre-erase in program space", pre_cnt, pre0);
    chk("R8", "busy length", blen, PROG_CYC);
    rd(6'h04, w);
    chk("R2", "read back", int'(w), 'h1A5C);
    lock_prog = 1'b1;
    rd(6'h04, w);
    chk("R7", "locked user read", int'(w), 0);

    inc_n('hFF);
    load(6'h02, 14'h0123);
    cmd(6'h08); track = 1;
    repeat (PROG_CYC + 20) @(negedge clk);
    rd(6'h04, w);
    chk("R7", "calibration word unmasked", int'(w), 'h0123);
    inc_n(1);
    rd(6'h04, w);
    chk("R7", "erased word masked", int'(w), 0);
    lock_prog = 1'b0;
    rd(6'h04, w);
    chk("R7", "erased word unlocked", int'(w), 'h3FFF);

    inc_n('hFF);
    chk("R4", "user top", int'(mem_addr), 'h1FF);
    inc_n(1);
    chk("R4", "user wrap", int'(mem_addr), 0);

    inc_n('h85);
    load(6'h03, 14'h3F5A);
    chk("R6", "data alias address", int'(mem_addr), 'h05);
    chk("R6", "data select", int'(mem_dsel), 1);
    we0 = we_cnt; pre0 = pre_cnt;
    cmd(6'h08); track = 1;
    repeat (PROG_CYC + 20) @(negedge clk);
    chk("R8", "data write strobe", we_cnt, we0 + 1);
    chk("R8", "data pre-erase", pre_cnt, pre0 + 1);
    rd(6'h05, w);
    chk("R6", "data byte read", int'(w), 'h005A);
    lock_data = 1'b1;
    rd(6'h05, w);
    chk("R7", "locked data read", int'(w), 0);
    lock_data = 1'b0;

    we0 = we_cnt;
    cmd(6'h08); exp_es = 1; track = 1;
    repeat (10) @(negedge clk);
    chk("R12", "no write without load", we_cnt, we0);
    chk("R12", "sequence flag", int'(err_seq), 1);
    chk("R12", "no busy", int'(busy), 0);

    bk0 = bulk_cnt;
    cmd(6'h0B);
    cmd(6'h06);
    exp_eb = 1; exp_dsel = 1; track = 1;
    chk("R11", "busy flag", int'(err_busy), 1);
    repeat (ERASE_CYC + 20) @(negedge clk);
    chk("R10", "bulk strobe", bulk_cnt, bk0 + 1);
    chk("R10", "erase busy length", blen, ERASE_CYC);
    rd(6'h05, w);
    chk("R10", "erased data byte", int'(w), 'h00FF);

    load(6'h02, 14'h2B1D);
    we0 = we_cnt; pre0 = pre_cnt;
    cmd(6'h18); track = 1;
    chk("R9", "ext write strobe", we_cnt, we0 + 1);
    chk("R9", "ext no pre-erase", pre_cnt, pre0);
    repeat (PROG_CYC * 3) @(negedge clk);
    chk("R9", "ext busy held", int'(busy), 1);
    cmd(6'h06); track = 1;
    chk("R11", "inc ignored while busy", int'(mem_addr), 'h85);
    cmd(6'h0A); track = 1;
    chk("R9", "busy cleared by end", int'(busy), 0);
    rd(6'h04, w);
    chk("R9", "ext word", int'(w), 'h2B1D);

    load(6'h00, 14'h0155);
    chk("R5", "config base", int'(mem_addr), CFGB);
    cmd(6'h08); track = 1;
    repeat (PROG_CYC + 20) @(negedge clk);
    lock_prog = 1'b1;
    rd(6'h04, w);
    chk("R7", "config read unmasked", int'(w), 'h0155);
    lock_prog = 1'b0;
    inc_n('h1FF);
    chk("R4", "config top", int'(mem_addr), 'h3FF);
    inc_n(1);
    chk("R4", "config wrap", int'(mem_addr), CFGB);

    track = 0;
    prog_en = 1'b0;
    repeat (4) @(negedge clk);
    exp_pc = 0; exp_dsel = 0; exp_eb = 0; exp_es = 0;
    chk("R5", "exit address", int'(mem_addr), 0);
    chk("R5", "exit flags", int'(err_busy | err_seq), 0);
    prog_en = 1'b1;
    repeat (3) @(negedge clk);
    track = 1;

    cmd(6'h36); exp_pc = 1; track = 1;
    chk("R1", "don't-care bits inc", int'(mem_addr), 1);
    load(6'h02, 14'h0777);
    we0 = we_cnt;
    cmd(6'h28); track = 1;
    chk("R1", "unmatched code no write", we_cnt, we0);
    chk("R1", "unmatched code no busy", int'(busy), 0);
    cmd(6'h08); track = 1;
    repeat (PROG_CYC + 20) @(negedge clk);
    chk("R1", "load kept after unmatched code", we_cnt, we0 + 1);
    rd(6'h04, w);
    chk("R2", "word at 1", int'(w), 'h0777);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule